// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is one timer channel that software sets up through a small synchronous register port. It counts down once per prescaled base tick. The base tick comes in as a clock-enable pulse, and a selectable divider of 1, 16 or 256 sits in front of the counter. Three run modes are available:

- **Periodic** restarts the count from a stored load value.
- **Free-running** restarts from the full scale of the selected counter size.
- **One-shot** stops once the count reaches zero.

The counter can be 16 or 32 bits wide. Each time the count reaches zero, a sticky raw flag is set. The interrupt output is that flag gated by an enable bit.

Two write paths exist for the load value. One store replaces the running count at once. The background store only changes the value that the next periodic reload picks up. Writes take effect on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`.

Top module: `dtimer_chan`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable set, disabled, free-running, 16-bit). The count reads 0, the load register reads 0, the raw flag is 0 and `irq` is low.
- R2: Byte offsets: 0x00 load, 0x04 count (read-only), 0x08 control, 0x0C flag clear (write-only, reads 0), 0x10 raw flag, 0x14 masked flag, 0x18 background load. Control bits are: 0 one-shot, 1 wide (32-bit), 3:2 prescale, 5 interrupt enable, 6 periodic, 7 enable. Both flag registers return the flag in bit 0.
- R3: A write to 0x00 stores the value and replaces the count on the same edge. This write takes priority over a count step in that cycle. Reads of 0x00 and of 0x18 both return the stored load value.
- R4: A write to 0x18 stores the load value and leaves the running count untouched. The new value is used at the next periodic reload.
- R5: Writes to the count register at 0x04 have no effect.
- R6: A step while the count is nonzero decrements it. A step that takes the count from 1 to 0 sets the raw flag. In periodic mode (bit 6 set, bit 0 clear), a step at zero reloads the stored load value.
- R7: In free-running mode (bits 6 and 0 clear), a step at zero reloads 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode, whatever the load register holds.
- R8: In one-shot mode (bit 0 set, which takes priority over bit 6), the count stays at zero after it reaches zero, and no reload takes place.
- R9: A step occurs only on a cycle where the channel is enabled and `tick_en` is high, once per 1, 16 or 256 such cycles for prescale values 0, 1 or 2. A prescale value of 3 divides by 1.
- R10: A control write restarts the prescale phase, and no step occurs in the cycle of that write.
- R11: In 16-bit mode only the low 16 bits of the count are used, and the count reads back with its upper 16 bits as zero.
- R12: Any write to 0x0C clears the raw flag. If the count expires in the same cycle, the flag stays set.
- R13: The masked flag and `irq` both equal the raw flag ANDed with control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Base tick clock enable |
| reg_wr | input | 1 | Write strobe, taken on the rising clock edge |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt, raw flag AND interrupt enable |

## Verification
Two pairs of functions can land on the same edge.

The first pair is an expiry and a flag-clear write. The bench provokes it by issuing the clear write on exactly the edge where a periodic count steps from 1 to 0. It judges the outcome by reading the raw flag afterwards: the flag must still be set, and the count must be zero.

The second pair is a load write and a count step. The bench lands the load write on an edge where a step is due. The count must read the written value, not one less.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

  localparam int unsigned REG_AW = 5;
  localparam int unsigned DATA_W = 32;

  localparam logic [REG_AW-1:0] OFS_LOAD   = 5'h00;
  localparam logic [REG_AW-1:0] OFS_COUNT  = 5'h04;
  localparam logic [REG_AW-1:0] OFS_CTRL   = 5'h08;
  localparam logic [REG_AW-1:0] OFS_CLEAR  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_RAW    = 5'h10;
  localparam logic [REG_AW-1:0] OFS_MASKED = 5'h14;
  localparam logic [REG_AW-1:0] OFS_BGLOAD = 5'h18;

  typedef enum logic [1:0] {
    RUN_FREE     = 2'd0,
    RUN_PERIODIC = 2'd1,
    RUN_ONESHOT  = 2'd2
  } run_mode_e;

  // bit 7 down to bit 0
  typedef struct packed {
    logic       enable;
    logic       periodic;
    logic       irq_en;
    logic       spare;
    logic [1:0] prescale;
    logic       wide;
    logic       oneshot;
  } ctrl_t;

  function automatic run_mode_e decode_mode(ctrl_t c);
    if (c.oneshot)       return RUN_ONESHOT;
    else if (c.periodic) return RUN_PERIODIC;
    else                 return RUN_FREE;
  endfunction

endpackage

// File: rtl/dtimer_prescale.sv
module dtimer_prescale #(
  parameter int unsigned PRE_W   = 8,
  parameter int unsigned LOG_MID = 4,
  parameter int unsigned LOG_TOP = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick_en,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       step
);

  localparam logic [PRE_W-1:0] TERM_ONE = '0;
  localparam logic [PRE_W-1:0] TERM_MID = PRE_W'((1 << LOG_MID) - 1);
  localparam logic [PRE_W-1:0] TERM_TOP = PRE_W'((1 << LOG_TOP) - 1);

  logic [PRE_W-1:0] phase_q, phase_d;
  logic [PRE_W-1:0] term;
  logic             hit;

  always_comb begin
    case (sel)
      2'd1:    term = TERM_MID;
      2'd2:    term = TERM_TOP;
      default: term = TERM_ONE;
    endcase
  end

  assign hit  = run && tick_en && (phase_q == term);
  assign step = hit && !restart;

  always_comb begin
    phase_d = phase_q;
    if (restart)              phase_d = '0;
    else if (run && tick_en)  phase_d = hit ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R9: a step needs enable and a tick
  p_step_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (run && tick_en));

  // R10: no step on a control write, phase restarts
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == '0));

endmodule

// File: rtl/dtimer_down_counter.sv
module dtimer_down_counter
  import dtimer_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             ld_now,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             wide,
  input  run_mode_e        mode,
  output logic [CNT_W-1:0] cnt_view,
  output logic             expire
);

  localparam logic [CNT_W-1:0] NARROW_MASK = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [CNT_W-1:0] ONE         = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] full_scale;

  assign cnt_view   = wide ? cnt_q : (cnt_q & NARROW_MASK);
  assign full_scale = wide ? '1 : NARROW_MASK;
  assign expire     = step && !ld_now && (cnt_view == ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (ld_now) begin
      cnt_d = ld_val;
    end else if (step) begin
      if (cnt_view != '0) begin
        cnt_d = cnt_view - ONE;
      end else begin
        case (mode)
          RUN_PERIODIC: cnt_d = reload_val;
          RUN_FREE:     cnt_d = full_scale;
          default:      cnt_d = cnt_view;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: load write replaces the count, winning over a step
  p_load_now_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_now |=> (cnt_q == $past(ld_val)));

  // R8: one-shot holds at zero
  p_oneshot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_now && mode == RUN_ONESHOT && cnt_view == '0) |=> (cnt_view == '0));

  // R9: count is frozen without a step or load
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ld_now) |=> $stable(cnt_q));

endmodule

// File: rtl/dtimer_chan.sv
module dtimer_chan
  import dtimer_pkg::*;
#(
  parameter int unsigned PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  localparam ctrl_t CTRL_RESET = '{irq_en: 1'b1, default: '0};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] load_q, load_d;
  logic              raw_q, raw_d;

  logic wr_load, wr_bg, wr_ctrl, wr_clear;
  logic step, expire;
  logic [DATA_W-1:0] cnt_view;
  run_mode_e mode;

  assign wr_load  = reg_wr && (reg_addr == OFS_LOAD);
  assign wr_bg    = reg_wr && (reg_addr == OFS_BGLOAD);
  assign wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_clear = reg_wr && (reg_addr == OFS_CLEAR);
  assign mode     = decode_mode(ctrl_q);

  always_comb begin
    ctrl_d = ctrl_q;
    load_d = load_q;
    if (wr_ctrl)          ctrl_d = ctrl_t'(reg_wdata[7:0]);
    if (wr_load || wr_bg) load_d = reg_wdata;
  end

  always_comb begin
    raw_d = raw_q;
    if (expire)        raw_d = 1'b1;
    else if (wr_clear) raw_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q <= CTRL_RESET;
      load_q <= '0;
      raw_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
      raw_q  <= raw_d;
    end
  end

  dtimer_prescale #(.PRE_W(PRE_W), .LOG_MID(4), .LOG_TOP(8)) u_prescale (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (ctrl_q.enable),
    .tick_en (tick_en),
    .restart (wr_ctrl),
    .sel     (ctrl_q.prescale),
    .step    (step)
  );

  dtimer_down_counter #(.CNT_W(DATA_W), .NARROW_W(16)) u_counter (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .step       (step),
    .ld_now     (wr_load),
    .ld_val     (reg_wdata),
    .reload_val (load_q),
    .wide       (ctrl_q.wide),
    .mode       (mode),
    .cnt_view   (cnt_view),
    .expire     (expire)
  );

  always_comb begin
    case (reg_addr)
      OFS_LOAD, OFS_BGLOAD: reg_rdata = load_q;
      OFS_COUNT:            reg_rdata = cnt_view;
      OFS_CTRL:             reg_rdata = {{(DATA_W-8){1'b0}}, ctrl_q};
      OFS_RAW:              reg_rdata = {{(DATA_W-1){1'b0}}, raw_q};
      OFS_MASKED:           reg_rdata = {{(DATA_W-1){1'b0}}, raw_q && ctrl_q.irq_en};
      default:              reg_rdata = '0;
    endcase
  end

  assign irq = raw_q && ctrl_q.irq_en;

  // R6: expiry sets the raw flag
  p_expire_sets_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    expire |=> raw_q);

  // R12: clear without expiry drops the flag
  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_clear && !expire) |=> !raw_q);

  // R4: background store keeps the count
  p_bg_keeps_count_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_bg && !step) |=> $stable(cnt_view));

  // R13: irq never rises with interrupts disabled
  p_irq_gated_r13: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> ctrl_q.irq_en);

endmodule

// File: tb/dtimer_chan_tb.sv
module dtimer_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dtimer_chan dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  localparam logic [4:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTRL = 5'h08,
    A_CLR = 5'h0C, A_RAW = 5'h10, A_MSK = 5'h14, A_BG = 5'h18;

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %h actual %h expected %h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_irq(input string req, input logic exp);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", req, irq, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1", A_CTRL, 32'h20);
    chk("R1", A_CNT, 0);
    chk("R1", A_LOAD, 0);
    chk("R1", A_RAW, 0);
    chk_irq("R1", 1'b0);
    chk("R2", A_CLR, 0);
  endtask

  task automatic t_load_and_ignore;
    wr(A_LOAD, 32'h0001_2345);
    chk("R3", A_LOAD, 32'h0001_2345);
    chk("R3", A_BG, 32'h0001_2345);
    chk("R11", A_CNT, 32'h0000_2345);
    wr(A_VALUE_IGN(), 32'hDEAD_BEEF);
    chk("R5", A_CNT, 32'h0000_2345);
    chk("R5", A_LOAD, 32'h0001_2345);
  endtask

  function automatic logic [4:0] A_VALUE_IGN();
    return A_CNT;
  endfunction

  task automatic t_periodic_and_clash;
    wr(A_CTRL, 32'h22);
    wr(A_LOAD, 3);
    wr(A_CTRL, 32'hE2);
    chk("R10", A_CNT, 3);
    idle(2);
    chk("R6", A_CNT, 1);
    chk("R6", A_RAW, 0);
    idle(1);
    chk("R6", A_CNT, 0);
    chk("R6", A_RAW, 1);
    chk("R13", A_MSK, 1);
    chk_irq("R13", 1'b1);
    idle(1);
    chk("R6", A_CNT, 3);
    wr(A_CLR, 0);
    chk("R12", A_RAW, 0);
    chk_irq("R12", 1'b0);
    chk("R12", A_CNT, 2);
    idle(1);
    wr(A_CLR, 0);
    chk("R12", A_CNT, 0);
    chk("R12", A_RAW, 1);
    wr(A_LOAD, 10);
    chk("R3", A_CNT, 10);
    wr(A_CLR, 0);
  endtask

  task automatic t_background;
    wr(A_CTRL, 32'h22);
    wr(A_LOAD, 3);
    wr(A_CTRL, 32'hE2);
    wr(A_BG, 5);
    chk("R4", A_CNT, 2);
    chk("R4", A_LOAD, 5);
    idle(2);
    chk("R4", A_CNT, 0);
    idle(1);
    chk("R4", A_CNT, 5);
    wr(A_CLR, 0);
  endtask

  task automatic t_oneshot;
    wr(A_CTRL, 32'h22);
    wr(A_LOAD, 2);
    wr(A_CTRL, 32'hE3);
    idle(2);
    chk("R8", A_CNT, 0);
    chk("R8", A_RAW, 1);
    idle(3);
    chk("R8", A_CNT, 0);
    wr(A_CLR, 0);
  endtask

  task automatic t_free;
    wr(A_CTRL, 32'h20);
    wr(A_LOAD, 5);
    wr(A_CLR, 0);
    wr(A_CTRL, 32'hA0);
    idle(5);
    chk("R7", A_CNT, 0);
    chk("R7", A_RAW, 1);
    idle(1);
    chk("R7", A_CNT, 32'h0000_FFFF);
    idle(1);
    chk("R11", A_CNT, 32'h0000_FFFE);
    wr(A_CTRL, 32'h20);
    wr(A_LOAD, 1);
    wr(A_CTRL, 32'hA2);
    idle(1);
    chk("R7", A_CNT, 0);
    idle(1);
    chk("R7", A_CNT, 32'hFFFF_FFFF);
    wr(A_CLR, 0);
  endtask

  task automatic t_prescale;
    wr(A_CTRL, 32'h02);
    wr(A_LOAD, 100);
    wr(A_CTRL, 32'hC6);
    idle(15);
    chk("R9", A_CNT, 100);
    idle(1);
    chk("R9", A_CNT, 99);
    wr(A_CTRL, 32'hCA);
    chk("R10", A_CNT, 99);
    idle(255);
    chk("R9", A_CNT, 99);
    idle(1);
    chk("R9", A_CNT, 98);
    wr(A_CTRL, 32'hC2);
    tick_en = 1'b0;
    idle(5);
    chk("R9", A_CNT, 98);
    tick_en = 1'b1;
    idle(1);
    chk("R9", A_CNT, 97);
  endtask

  task automatic t_mask;
    wr(A_CTRL, 32'hC2);
    wr(A_CLR, 0);
    wr(A_LOAD, 1);
    idle(1);
    chk("R13", A_RAW, 1);
    chk("R13", A_MSK, 0);
    chk_irq("R13", 1'b0);
    wr(A_CTRL, 32'h62);
    chk("R13", A_MSK, 1);
    chk_irq("R13", 1'b1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_load_and_ignore();
    t_periodic_and_clash();
    t_background();
    t_oneshot();
    t_free();
    t_prescale();
    t_mask();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule